// File: doc/BRIEF.md
# Configurable Four-Valued Lookup Table

This block realises any combinational function of N data inputs onto M outputs through a lookup table. Software or a sequencer loads the table at run time. Every entry holds one of four results: drive low, drive high, unknown, or released (high-impedance). Each data input bit comes with a flag that marks it as unknown. Each output leaves the block as three wires: a value bit, an unknown flag and an output enable. A released result therefore shows up as a deasserted enable.

The table has M groups of 2^N entries, one group for each output, in output order. Inside a group, the data inputs form the index, with input bit 0 as its least significant bit. A single write port stores one entry per clock. The result for each output is looked up in its own group and then registered. When any input carries the unknown flag, the table is bypassed and every output reports unknown.

Top module: `cfg_lut4v`

## Requirements
- R1: While reset is asserted, every output has enable 0, unknown 0 and value 0. Reset clears every table entry to code 00, so the first evaluation after reset drives every output low.
- R2: Entry codes map onto the three output wires (enable, unknown, value) as follows: 00 gives 1,0,0 (low); 01 gives 1,0,1 (high); 10 gives 1,1,0 (unknown); 11 gives 0,0,0 (released).
- R3: Output k is looked up in the entries at write addresses k·2^N to k·2^N + 2^N − 1.
- R4: Within a group, the entry offset equals the input vector read as a binary number with input bit 0 as the LSB. Offset 0 applies when all inputs are zero and the last offset applies when all inputs are one.
- R5: If any input unknown flag is set, every output shows enable 1, unknown 1 and value 0, whatever the table holds.
- R6: Outputs are registered. A result follows from the inputs sampled at a clock edge and appears after that edge. The outputs do not move between edges.
- R7: A write strobe that is high at a clock edge stores the 2-bit code at the given address. The first evaluation that uses the new entry is the one at the following edge.
- R8: A write to an address of M·2^N or above leaves every entry unchanged. The address port has one bit more than the table needs, so such addresses do not alias onto real entries.
- R9: Loaded tables reproduce known functions: 0,0,0,1 gives AND; 0,0,1,0 gives (NOT in0) AND in1; 0,1,1,0 with 0,0,0,1 gives the sum and carry of a half adder; Z,1,Z,0 gives a tristate inverter (in0 = enable, in1 = data); 0,1,1,0,1,0,0,1 gives odd parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_val | input | N_IN | Data input bits, bit 0 is the index LSB |
| in_unk | input | N_IN | Per-bit unknown flags for the data inputs |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW | Entry address, group × 2^N + offset |
| wr_code | input | 2 | Entry code: 00 low, 01 high, 10 unknown, 11 released |
| out_val | output | M_OUT | Output value bits |
| out_unk | output | M_OUT | Output unknown flags |
| out_oe | output | M_OUT | Output enables, 0 for a released output |

## Verification
A lookup result is due exactly one clock edge after the inputs are presented. A table write becomes visible one edge later than that: it is stored at one edge, and the evaluation at the next edge uses it. The bench changes its inputs on falling edges and reads the outputs at the next falling edge. The latency and write checks also read just before the deciding rising edge, to confirm that the old value still holds there. After reset release, the bench leaves several idle cycles so that the internal reset synchroniser has settled before anything is compared.

// File: rtl/lut4v_pkg.sv
package lut4v_pkg;

  typedef enum logic [1:0] {
    LV_LOW  = 2'b00,
    LV_HIGH = 2'b01,
    LV_UNK  = 2'b10,
    LV_HIZ  = 2'b11
  } lv_code_e;

  typedef struct packed {
    logic oe;
    logic unk;
    logic val;
  } pin_drive_t;

  function automatic pin_drive_t code_to_drive(input logic [1:0] code, input logic force_unk);
    pin_drive_t d;
    if (force_unk) begin
      d = '{oe: 1'b1, unk: 1'b1, val: 1'b0};
    end else begin
      unique case (lv_code_e'(code))
        LV_LOW:  d = '{oe: 1'b1, unk: 1'b0, val: 1'b0};
        LV_HIGH: d = '{oe: 1'b1, unk: 1'b0, val: 1'b1};
        LV_UNK:  d = '{oe: 1'b1, unk: 1'b1, val: 1'b0};
        default: d = '{oe: 1'b0, unk: 1'b0, val: 1'b0};
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/lut4v_rst_sync.sv
module lut4v_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/lut4v_store.sv
module lut4v_store #(
  parameter int N_IN  = 3,
  parameter int M_OUT = 2,
  parameter int AW    = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [AW-1:0]                      wr_addr,
  input  logic [1:0]                         wr_code,
  output logic [(M_OUT<<N_IN)-1:0][1:0]      tbl
);
  localparam int DEPTH = M_OUT << N_IN;

  logic [DEPTH-1:0][1:0] tbl_q;
  logic [DEPTH-1:0][1:0] tbl_d;
  logic                  tbl_ce;

  // next state: address compare per entry, so out-of-range addresses hit nothing
  always_comb begin
    tbl_d  = tbl_q;
    tbl_ce = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_addr == AW'(i))) begin
        tbl_d[i] = wr_code;
        tbl_ce   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (tbl_ce) begin
      tbl_q <= tbl_d;
    end
  end

  assign tbl = tbl_q;
endmodule

// File: rtl/lut4v_eval.sv
module lut4v_eval
  import lut4v_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int M_OUT = 2
) (
  input  logic [(M_OUT<<N_IN)-1:0][1:0] tbl,
  input  logic [N_IN-1:0]               in_val,
  input  logic [N_IN-1:0]               in_unk,
  output pin_drive_t [M_OUT-1:0]        drv
);
  localparam int GRP = 1 << N_IN;

  logic any_unk;
  assign any_unk = |in_unk;

  for (genvar k = 0; k < M_OUT; k++) begin : g_out
    logic [GRP-1:0][1:0] grp;
    logic [1:0]          sel;
    assign grp    = tbl[k*GRP +: GRP];
    assign sel    = grp[in_val];
    assign drv[k] = code_to_drive(sel, any_unk);
  end
endmodule

// File: rtl/lut4v_drvreg.sv
module lut4v_drvreg
  import lut4v_pkg::*;
#(
  parameter int M_OUT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pin_drive_t [M_OUT-1:0]  d,
  output pin_drive_t [M_OUT-1:0]  q
);
  pin_drive_t [M_OUT-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/cfg_lut4v.sv
module cfg_lut4v
  import lut4v_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int M_OUT = 2,
  parameter int AW    = $clog2(M_OUT << N_IN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  in_val,
  input  logic [N_IN-1:0]  in_unk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [1:0]       wr_code,
  output logic [M_OUT-1:0] out_val,
  output logic [M_OUT-1:0] out_unk,
  output logic [M_OUT-1:0] out_oe
);
  localparam int DEPTH = M_OUT << N_IN;

  logic                   rst_n_sync;
  logic [DEPTH-1:0][1:0]  tbl;
  pin_drive_t [M_OUT-1:0] drv_d;
  pin_drive_t [M_OUT-1:0] drv_q;

  lut4v_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lut4v_store #(.N_IN(N_IN), .M_OUT(M_OUT), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_code (wr_code),
    .tbl     (tbl)
  );

  lut4v_eval #(.N_IN(N_IN), .M_OUT(M_OUT)) u_eval (
    .tbl    (tbl),
    .in_val (in_val),
    .in_unk (in_unk),
    .drv    (drv_d)
  );

  lut4v_drvreg #(.M_OUT(M_OUT)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d     (drv_d),
    .q     (drv_q)
  );

  for (genvar k = 0; k < M_OUT; k++) begin : g_pin
    assign out_val[k] = drv_q[k].val;
    assign out_unk[k] = drv_q[k].unk;
    assign out_oe[k]  = drv_q[k].oe;
  end
endmodule

// File: rtl/lut4v_chk.sv
module lut4v_chk #(
  parameter int N_IN  = 3,
  parameter int M_OUT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  in_val,
  input logic [N_IN-1:0]  in_unk,
  input logic             wr_en,
  input logic [M_OUT-1:0] out_val,
  input logic [M_OUT-1:0] out_unk,
  input logic [M_OUT-1:0] out_oe
);
  // counts edges since reset release, covering the internal reset synchroniser
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= 2'd0;
    end else if (warm_q != 2'd3) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  // R1: outputs idle while reset is held
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (out_oe == '0 && out_unk == '0 && out_val == '0));

  // R2: a released output carries neither value nor unknown flag
  p_hiz_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_val | out_unk) & ~out_oe) == '0);

  // R2: unknown outputs are enabled and carry value 0
  p_unk_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_unk & out_val) | (out_unk & ~out_oe)) == '0);

  // R5: an unknown input bit makes every output unknown one edge later
  p_unk_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && (|in_unk)) |=> (out_unk == '1 && out_oe == '1));

  // R6: with inputs and table unchanged, outputs hold
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $stable(in_val) && $stable(in_unk) && !$past(wr_en))
    |=> ($stable(out_val) && $stable(out_unk) && $stable(out_oe)));
endmodule

bind cfg_lut4v lut4v_chk #(.N_IN(N_IN), .M_OUT(M_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_val  (in_val),
  .in_unk  (in_unk),
  .wr_en   (wr_en),
  .out_val (out_val),
  .out_unk (out_unk),
  .out_oe  (out_oe)
);

// File: tb/cfg_lut4v_tb.sv
module cfg_lut4v_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  // two-input, two-output instance
  logic [1:0] a_in, a_unk;
  logic       a_we;
  logic [3:0] a_addr;
  logic [1:0] a_code;
  logic [1:0] a_val, a_uo, a_oe;

  // three-input, one-output instance
  logic [2:0] p_in, p_unk;
  logic       p_we;
  logic [3:0] p_addr;
  logic [1:0] p_code;
  logic [0:0] p_val, p_uo, p_oe;

  cfg_lut4v #(.N_IN(2), .M_OUT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_val(a_in), .in_unk(a_unk),
    .wr_en(a_we), .wr_addr(a_addr), .wr_code(a_code),
    .out_val(a_val), .out_unk(a_uo), .out_oe(a_oe));

  cfg_lut4v #(.N_IN(3), .M_OUT(1)) u_dut_par (
    .clk(clk), .rst_n(rst_n), .in_val(p_in), .in_unk(p_unk),
    .wr_en(p_we), .wr_addr(p_addr), .wr_code(p_code),
    .out_val(p_val), .out_unk(p_uo), .out_oe(p_oe));

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // {group0 entries e3..e0 (8b), input (2b), expected code out0, expected code out1}
  localparam logic [13:0] VEC [0:11] = '{
    {8'h40, 2'd0, 2'b00, 2'b00}, {8'h40, 2'd1, 2'b00, 2'b01},
    {8'h40, 2'd2, 2'b00, 2'b01}, {8'h40, 2'd3, 2'b01, 2'b00},
    {8'h10, 2'd0, 2'b00, 2'b00}, {8'h10, 2'd1, 2'b00, 2'b01},
    {8'h10, 2'd2, 2'b01, 2'b01}, {8'h10, 2'd3, 2'b00, 2'b00},
    {8'h37, 2'd0, 2'b11, 2'b00}, {8'h37, 2'd1, 2'b01, 2'b01},
    {8'h37, 2'd2, 2'b11, 2'b01}, {8'h37, 2'd3, 2'b00, 2'b00}
  };

  // {oe, unk, val} expected for a code, per R2
  function automatic logic [2:0] drv(input logic [1:0] c);
    case (c)
      2'b00:   return 3'b100;
      2'b01:   return 3'b101;
      2'b10:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [5:0] a_got();
    return {a_oe[1], a_uo[1], a_val[1], a_oe[0], a_uo[0], a_val[0]};
  endfunction

  task automatic check(input string req, input string what, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic wr_a(input int addr, input logic [1:0] code);
    a_we = 1'b1; a_addr = 4'(addr); a_code = code;
    @(negedge clk);
    a_we = 1'b0;
  endtask

  task automatic wr_p(input int addr, input logic [1:0] code);
    p_we = 1'b1; p_addr = 4'(addr); p_code = code;
    @(negedge clk);
    p_we = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    rst_n = 1'b0;
    a_in = '0; a_unk = '0; a_we = 1'b0; a_addr = '0; a_code = '0;
    p_in = '0; p_unk = '0; p_we = 1'b0; p_addr = '0; p_code = '0;
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", a_got(), 6'b000000);
    check("R1", "parity output in reset", {3'b0, p_oe, p_uo, p_val}, 6'b000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "cleared table drives low", a_got(), {drv(2'b00), drv(2'b00)});

    // R3: group 1 holds the half-adder sum 0,1,1,0
    wr_a(4, 2'b00); wr_a(5, 2'b01); wr_a(6, 2'b01); wr_a(7, 2'b00);

    cur = 8'hFF;
    for (int v = 0; v < 12; v++) begin
      if (VEC[v][13:6] != cur) begin
        cur = VEC[v][13:6];
        for (int e = 0; e < 4; e++) wr_a(e, cur[2*e +: 2]);
      end
      a_in = VEC[v][5:4];
      @(negedge clk);
      check("R9", $sformatf("vector %0d (R3 R4)", v), a_got(), {drv(VEC[v][1:0]), drv(VEC[v][3:2])});
    end

    // R5: unknown input forces unknown on both outputs, whatever the table
    a_in = 2'd1; a_unk = 2'b10;
    @(negedge clk);
    check("R5", "unknown flag on bit 1", a_got(), {drv(2'b10), drv(2'b10)});
    a_unk = 2'b00;
    @(negedge clk);
    check("R5", "flag cleared", a_got(), {drv(2'b01), drv(2'b01)});

    // R6: result appears only after the edge following the input change
    a_in = 2'd3;
    #1 check("R6", "old result holds before edge", a_got(), {drv(2'b01), drv(2'b01)});
    @(negedge clk);
    check("R6", "new result after edge", a_got(), {drv(2'b00), drv(2'b00)});

    // R8: out-of-range addresses 8 and 12 would alias onto 0 and 4 if truncated
    wr_a(8, 2'b01); wr_a(12, 2'b10);
    a_in = 2'd0;
    @(negedge clk);
    check("R8", "out-of-range writes ignored", a_got(), {drv(2'b00), drv(2'b11)});

    // R7: write lands at one edge, used at the next
    a_we = 1'b1; a_addr = 4'd0; a_code = 2'b10;
    @(negedge clk);
    a_we = 1'b0;
    check("R7", "old entry used at write edge", a_got(), {drv(2'b00), drv(2'b11)});
    @(negedge clk);
    check("R7", "new entry used next edge", a_got(), {drv(2'b00), drv(2'b10)});

    // R9 parity on the three-input instance
    for (int e = 0; e < 8; e++) wr_p(e, {1'b0, ^3'(e)});
    for (int i = 0; i < 8; i++) begin
      p_in = 3'(i);
      @(negedge clk);
      check("R9", $sformatf("parity input %0d (R4)", i), {3'b0, p_oe, p_uo, p_val}, {3'b0, drv({1'b0, ^3'(i)})});
    end
    p_unk = 3'b001;
    @(negedge clk);
    check("R5", "parity with unknown bit 0", {3'b0, p_oe, p_uo, p_val}, {3'b0, drv(2'b10)});
    p_unk = '0;

    // R1: reset mid-run clears outputs and table
    rst_n = 1'b0;
    #1 check("R1", "async reset clears outputs", a_got(), 6'b000000);
    @(negedge clk);
    rst_n = 1'b1;
    a_in = 2'd1;
    repeat (4) @(negedge clk);
    check("R1", "table cleared by reset", a_got(), {drv(2'b00), drv(2'b00)});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule